// File: doc/BRIEF.md
# RTC Register File Bus Interface

This block sits between an 8-bit processor bus and the 64-byte register file of a real-time-clock style peripheral. It gives the bus two ways to reach the same storage, selected by the `map_direct` strap. In indexed mode, the bus uses two neighbouring port addresses. A write to the even address loads an index register, and reads and writes at the odd address reach the register that index names. In direct mode, the register number comes straight from the address bits, so the file looks like a small RAM. The per-register rules are the same in both modes.

Several registers have side effects on access. The status register holds three event flags and a summary interrupt bit, and a read of it clears the flags. The control register's enable bits decide which flags drive the active-low interrupt pin. Register A reports an update-in-progress (UIP) bit, which a two-state timer (states `UIP_IDLE` and `UIP_BUSY`) holds for a fixed number of time-base ticks after each refresh pulse. The timer goes from `UIP_IDLE` to `UIP_BUSY` on a refresh pulse. It stays in `UIP_BUSY` and reloads its count on any further refresh. It returns to `UIP_IDLE` when the tick that exhausts the count arrives.

The timekeeping counters, alarm comparison and periodic-rate generation are not part of this block. They reach it as single-cycle flag-set pulses, a refresh pulse and a tick enable. When a write changes register A, the block reports it on a restart pulse output.

Top module: `rtc_regbus_top`

## Requirements
- R1: With `map_direct`=0, a write with `bus_addr[0]`=0 loads the index from `bus_wdata[5:0]`. A read or write with `bus_addr[0]`=1 reaches the register that the index names. A read with `bus_addr[0]`=0 returns 0x00.
- R2: With `map_direct`=1, `bus_addr[5:0]` names the register, and every rule below applies exactly as it does in indexed mode. Both modes share one storage.
- R3: A read of register C (0x0C) returns IRQF in bit 7, PF in bit 6, AF in bit 5 and UF in bit 4. Bits 3..0 are always 0.
- R4: A read of register C clears PF, AF and UF, and therefore IRQF, in the same access. A set pulse that arrives in the same cycle as that read wins, and its flag stays set.
- R5: A read of register D (0x0D) always returns bit 7 as 1. After reset it reads 0x80.
- R6: Writes to registers C and D are ignored. A write to C does not clear any flag.
- R7: A write to register 0x00 stores the data with bit 7 cleared.
- R8: In register A (0x0A), bit 7 reads as UIP and cannot be written. A write stores bits 6..0 only if they differ from the stored bits 6..0. Such a write alone raises `div_restart` for one cycle, starting in the cycle after the write.
- R9: UIP reads as 1 from the cycle after a `refresh` pulse until `UIP_TICKS` cycles with `tick`=1 have passed. A further `refresh` inside the window reloads the full count, and `refresh` takes priority over `tick`.
- R10: In register B (0x0B), SET is bit 7, PIE is bit 6, AIE is bit 5 and UIE is bit 4. A write that sets SET while the stored SET is 0 stores UIE as 0.
- R11: `set_pf`, `set_af` and `set_uf` set PF, AF and UF whatever the enables hold. IRQF is 1 when any flag is 1 together with its enable bit in B. `irq_n` is 0 exactly while IRQF is 1.
- R12: `bus_rdata` is registered. It changes only in the cycle after a read and holds its value otherwise. After reset, `bus_rdata` is 0x00, `irq_n` is 1 and `div_restart` is 0.
- R13: All other registers store and return the written byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_direct | input | 1 | 1 = direct register addressing, 0 = indexed addressing |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 8 | Registered read data |
| tick | input | 1 | Time-base tick enable for the UIP window |
| refresh | input | 1 | Update-refresh pulse that opens the UIP window |
| set_pf | input | 1 | Periodic flag set pulse |
| set_af | input | 1 | Alarm flag set pulse |
| set_uf | input | 1 | Update flag set pulse |
| irq_n | output | 1 | Active-low interrupt |
| div_restart | output | 1 | One-cycle pulse after a write that changes register A |

## Verification
The properties assume that `bus_rd` and `bus_wr` are never high in the same cycle, and that `map_direct` changes only between accesses. They also assume that all pulses are synchronous to `clk`. The properties on status-register reads, such as clear-on-read and interrupt release, are stated for direct-mode accesses only, because that mode needs no tracking of the index. The stimulus drives every input on the falling edge. It keeps read and write exclusive, including in the random phase. Only the mode strap, address, data and event pulses are randomised.

// File: rtl/rtc_regbus_pkg.sv
package rtc_regbus_pkg;

    localparam int DATA_W     = 8;

    // Register numbers whose behaviour is special.
    localparam int REG_SEC    = 0;
    localparam int REG_A      = 10;
    localparam int REG_B      = 11;
    localparam int REG_C      = 12;
    localparam int REG_D      = 13;

    // Bit positions used by the access rules.
    localparam int SEC_RO_BIT = 7;
    localparam int BIT_UIP    = 7;
    localparam int BIT_SET    = 7;
    localparam int BIT_UIE    = 4;
    localparam int BIT_VRT    = 7;
    localparam int FLAG_LSB   = 4;
    localparam int N_FLAGS    = 3;

    typedef enum logic [0:0] {
        UIP_IDLE = 1'b0,
        UIP_BUSY = 1'b1
    } uip_state_e;

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_direct,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] idx_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_sel,
    output logic              port_rd
);

    logic [ADDR_W-1:0] idx_q;
    logic              data_port;
    logic              idx_load;

    // In indexed mode only the odd address reaches the file.
    assign data_port = map_direct | bus_addr[0];
    assign idx_load  = bus_wr & ~data_port;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_load) begin
            idx_q <= idx_wdata;
        end
    end

    always_comb begin
        acc_sel = map_direct ? bus_addr : idx_q;
        acc_rd  = bus_rd & data_port;
        acc_wr  = bus_wr & data_port;
        port_rd = bus_rd & ~data_port;
    end

endmodule

// File: rtl/rtc_uip_timer.sv
module rtc_uip_timer
    import rtc_regbus_pkg::*;
#(
    parameter int UIP_TICKS = 73
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh,
    input  logic tick,
    output logic uip
);

    localparam int CNT_W = $clog2(UIP_TICKS + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(UIP_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    uip_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UIP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions: refresh opens or reloads, the last tick closes.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            UIP_IDLE: begin
                if (refresh) begin
                    state_d = UIP_BUSY;
                    cnt_d   = LOAD;
                end
            end
            UIP_BUSY: begin
                if (refresh) begin
                    cnt_d = LOAD;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        state_d = UIP_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - LAST;
                    end
                end
            end
            default: begin
                state_d = UIP_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        uip = (state_q == UIP_BUSY);
    end

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_regbus_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              port_rd,
    input  logic [ADDR_W-1:0] acc_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              uip,
    input  logic              set_pf,
    input  logic              set_af,
    input  logic              set_uf,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_n,
    output logic              div_restart
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] SEL_SEC = ADDR_W'(REG_SEC);
    localparam logic [ADDR_W-1:0] SEL_A   = ADDR_W'(REG_A);
    localparam logic [ADDR_W-1:0] SEL_B   = ADDR_W'(REG_B);
    localparam logic [ADDR_W-1:0] SEL_C   = ADDR_W'(REG_C);
    localparam logic [ADDR_W-1:0] SEL_D   = ADDR_W'(REG_D);

    logic [DATA_W-1:0]  regs [DEPTH];
    logic [N_FLAGS-1:0] flag_q;
    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flag_en;
    logic               irqf;
    logic               is_sec, is_a, is_b, is_c, is_d;
    logic               wr_store, restart_d;
    logic [DATA_W-1:0]  wr_value, rd_value;
    logic               clr_flags;

    always_comb begin
        is_sec = (acc_sel == SEL_SEC);
        is_a   = (acc_sel == SEL_A);
        is_b   = (acc_sel == SEL_B);
        is_c   = (acc_sel == SEL_C);
        is_d   = (acc_sel == SEL_D);
    end

    // Write rules per register.
    always_comb begin
        wr_store  = 1'b0;
        restart_d = 1'b0;
        wr_value  = wdata;
        if (acc_wr) begin
            if (is_c || is_d) begin
                wr_store = 1'b0;
            end else if (is_sec) begin
                wr_store             = 1'b1;
                wr_value[SEC_RO_BIT] = 1'b0;
            end else if (is_a) begin
                if (wdata[BIT_UIP-1:0] != regs[REG_A][BIT_UIP-1:0]) begin
                    wr_store          = 1'b1;
                    restart_d         = 1'b1;
                    wr_value[BIT_UIP] = 1'b0;
                end
            end else if (is_b) begin
                wr_store = 1'b1;
                if (wdata[BIT_SET] && !regs[REG_B][BIT_SET]) begin
                    wr_value[BIT_UIE] = 1'b0;
                end
            end else begin
                wr_store = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_store) begin
            regs[acc_sel] <= wr_value;
        end
    end

    // Event flags: one cell per flag, set beats read-clear.
    assign flag_set  = {set_pf, set_af, set_uf};
    assign clr_flags = acc_rd & is_c;
    assign flag_en   = regs[REG_B][FLAG_LSB +: N_FLAGS];

    for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[f] <= 1'b0;
            end else if (flag_set[f]) begin
                flag_q[f] <= 1'b1;
            end else if (clr_flags) begin
                flag_q[f] <= 1'b0;
            end
        end
    end

    assign irqf  = |(flag_q & flag_en);
    assign irq_n = ~irqf;

    // Read rules per register.
    always_comb begin
        rd_value = regs[acc_sel];
        if (is_a) begin
            rd_value[BIT_UIP] = uip;
        end else if (is_c) begin
            rd_value = {irqf, flag_q, {FLAG_LSB{1'b0}}};
        end else if (is_d) begin
            rd_value[BIT_VRT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata       <= '0;
            div_restart <= 1'b0;
        end else begin
            div_restart <= restart_d;
            if (acc_rd) begin
                rdata <= rd_value;
            end else if (port_rd) begin
                rdata <= '0;
            end
        end
    end

endmodule

// File: rtl/rtc_regbus_top.sv
module rtc_regbus_top
    import rtc_regbus_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int UIP_TICKS = 73
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_direct,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    input  logic              refresh,
    input  logic              set_pf,
    input  logic              set_af,
    input  logic              set_uf,
    output logic              irq_n,
    output logic              div_restart
);

    logic              acc_rd, acc_wr, port_rd;
    logic [ADDR_W-1:0] acc_sel;
    logic              uip;

    rtc_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .map_direct (map_direct),
        .bus_addr   (bus_addr),
        .idx_wdata  (bus_wdata[ADDR_W-1:0]),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .acc_rd     (acc_rd),
        .acc_wr     (acc_wr),
        .acc_sel    (acc_sel),
        .port_rd    (port_rd)
    );

    rtc_uip_timer #(.UIP_TICKS(UIP_TICKS)) u_uip (
        .clk     (clk),
        .rst_n   (rst_n),
        .refresh (refresh),
        .tick    (tick),
        .uip     (uip)
    );

    rtc_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_rd      (acc_rd),
        .acc_wr      (acc_wr),
        .port_rd     (port_rd),
        .acc_sel     (acc_sel),
        .wdata       (bus_wdata),
        .uip         (uip),
        .set_pf      (set_pf),
        .set_af      (set_af),
        .set_uf      (set_uf),
        .rdata       (bus_rdata),
        .irq_n       (irq_n),
        .div_restart (div_restart)
    );

endmodule

// File: rtl/rtc_regbus_sva.sv
module rtc_regbus_sva #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              map_direct,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic              set_pf,
    input logic              set_af,
    input logic              set_uf,
    input logic              irq_n,
    input logic              div_restart
);

    logic rd_c, rd_d, rd_s, wr_s, set_any;

    assign rd_c    = bus_rd && map_direct && (bus_addr == ADDR_W'(12));
    assign rd_d    = bus_rd && map_direct && (bus_addr == ADDR_W'(13));
    assign rd_s    = bus_rd && map_direct && (bus_addr == ADDR_W'(0));
    assign wr_s    = bus_wr && map_direct && (bus_addr == ADDR_W'(0));
    assign set_any = set_pf || set_af || set_uf;

    AST_C_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_c |=> (bus_rdata[3:0] == 4'h0)); // R3
    AST_C_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_c && !set_any) ##1 rd_c |=> (bus_rdata[7:4] == 4'h0)); // R4
    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (rd_c && !set_any) |=> irq_n); // R4
    AST_D_VRT: assert property (@(posedge clk) disable iff (!rst_n) rd_d |=> bus_rdata[7]); // R5
    AST_SEC_MSB: assert property (@(posedge clk) disable iff (!rst_n) wr_s ##1 rd_s |=> !bus_rdata[7]); // R7
    AST_RESTART_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) div_restart |-> $past(bus_wr)); // R8
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_n) |-> $past(set_any || bus_wr)); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |=> $stable(bus_rdata)); // R12
    AST_RESET_IRQ: assert property (@(posedge clk) !rst_n |=> irq_n); // R12

endmodule

bind rtc_regbus_top rtc_regbus_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .map_direct  (map_direct),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .set_pf      (set_pf),
    .set_af      (set_af),
    .set_uf      (set_uf),
    .irq_n       (irq_n),
    .div_restart (div_restart)
);

// File: tb/sim_rtc_regbus_top.sv
`timescale 1ns/1ps
module sim_rtc_regbus_top;

    localparam int AW    = 6;
    localparam int TICKS = 73;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          map_direct = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic          tick = 1'b0;
    logic          refresh = 1'b0;
    logic          set_pf = 1'b0;
    logic          set_af = 1'b0;
    logic          set_uf = 1'b0;
    logic [7:0]    bus_rdata;
    logic          irq_n;
    logic          div_restart;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;

    always #5 clk = ~clk;

    rtc_regbus_top #(.ADDR_W(AW), .UIP_TICKS(TICKS)) u0 (
        .clk(clk), .rst_n(rst_n), .map_direct(map_direct), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tick(tick), .refresh(refresh), .set_pf(set_pf), .set_af(set_af),
        .set_uf(set_uf), .irq_n(irq_n), .div_restart(div_restart)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int    m_mem [64];
    int    m_idx = 0;
    int    m_uip = 0;
    int    m_rdata = 0;
    int    m_sel = 0;
    int    m_nb = 0;
    bit    m_pf = 0, m_af = 0, m_uf = 0, m_restart = 0, m_dat = 0;
    string m_tag = "R12";

    function automatic bit m_irqf();
        return (m_pf && m_mem[11][6]) || (m_af && m_mem[11][5]) || (m_uf && m_mem[11][4]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_idx = 0; m_uip = 0; m_rdata = 0; m_restart = 0;
            m_pf = 0; m_af = 0; m_uf = 0; m_tag = "R12";
        end else begin
            m_restart = 0;
            m_dat = map_direct || bus_addr[0];
            m_sel = map_direct ? int'(bus_addr) : m_idx;
            if (bus_rd) begin
                if (!m_dat) begin
                    m_rdata = 0; m_tag = "R1";
                end else if (m_sel == 10) begin
                    m_rdata = (m_uip > 0 ? 128 : 0) + (m_mem[10] % 128); m_tag = "R9";
                end else if (m_sel == 12) begin
                    m_rdata = (m_irqf() ? 128 : 0) + (m_pf ? 64 : 0) + (m_af ? 32 : 0) + (m_uf ? 16 : 0);
                    m_pf = 0; m_af = 0; m_uf = 0; m_tag = "R3";
                end else if (m_sel == 13) begin
                    m_rdata = 128 + (m_mem[13] % 128); m_tag = "R5";
                end else begin
                    m_rdata = m_mem[m_sel]; m_tag = (m_sel == 0) ? "R7" : "R13";
                end
            end
            if (bus_wr) begin
                if (!m_dat) begin
                    m_idx = int'(bus_wdata) % 64;
                end else if (m_sel == 0) begin
                    m_mem[0] = int'(bus_wdata) % 128;
                end else if (m_sel == 10) begin
                    if ((int'(bus_wdata) % 128) != (m_mem[10] % 128)) begin
                        m_mem[10] = int'(bus_wdata) % 128;
                        m_restart = 1;
                    end
                end else if (m_sel == 11) begin
                    m_nb = int'(bus_wdata);
                    if (m_nb >= 128 && m_mem[11] < 128 && m_nb[4]) m_nb = m_nb - 16;
                    m_mem[11] = m_nb;
                end else if (m_sel != 12 && m_sel != 13) begin
                    m_mem[m_sel] = int'(bus_wdata);
                end
            end
            if (set_pf) m_pf = 1;
            if (set_af) m_af = 1;
            if (set_uf) m_uf = 1;
            if (refresh) m_uip = TICKS;
            else if (tick && m_uip > 0) m_uip--;
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (started) begin
            chk(m_tag, int'(bus_rdata), m_rdata);
            chk("R11", int'(irq_n), m_irqf() ? 0 : 1);
            chk("R8", int'(div_restart), int'(m_restart));
        end
    end

    task automatic op(input bit rd, input bit wr, input int addr, input int data);
        bus_rd = rd; bus_wr = wr;
        bus_addr = addr[AW-1:0]; bus_wdata = data[7:0];
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdchk(input int addr, input int exp, input string tag);
        op(1'b1, 1'b0, addr, 0);
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL R12: watchdog expired, actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(1);
        started = 1'b1;
        idle(2);
        chk("R12", int'(bus_rdata), 0);
        chk("R12", int'(irq_n), 1);
        chk("R12", int'(div_restart), 0);
        rst_n = 1'b1;
        idle(1);

        // Direct mode basic rules
        map_direct = 1'b1;
        op(0, 1, 0, 'hFF);   rdchk(0, 'h7F, "R7");
        op(0, 1, 'h20, 'hA5); rdchk('h20, 'hA5, "R13");
        op(0, 1, 12, 'hFF);  rdchk(12, 'h00, "R6");
        op(0, 1, 13, 'h00);  rdchk(13, 'h80, "R5");

        // Register A: change detection and restart pulse
        op(0, 1, 10, 'h26);  chk("R8", int'(div_restart), 1);
        idle(1);             chk("R8", int'(div_restart), 0);
        op(0, 1, 10, 'h26);  chk("R8", int'(div_restart), 0);
        op(0, 1, 10, 'hA6);  chk("R8", int'(div_restart), 0);
        rdchk(10, 'h26, "R8");

        // Register B: SET gating of UIE
        op(0, 1, 11, 'h90);  rdchk(11, 'h80, "R10");
        op(0, 1, 11, 'h90);  rdchk(11, 'h90, "R10");
        op(0, 1, 11, 'h00);  rdchk(11, 'h00, "R10");

        // Flags and interrupt
        op(0, 1, 11, 'h70);
        set_af = 1'b1; idle(1); set_af = 1'b0;
        chk("R11", int'(irq_n), 0);
        rdchk(12, 'hA0, "R3");
        chk("R4", int'(irq_n), 1);
        rdchk(12, 'h00, "R4");
        op(0, 1, 11, 'h00);
        set_pf = 1'b1; idle(1); set_pf = 1'b0;
        chk("R11", int'(irq_n), 1);
        op(0, 1, 12, 'h00);
        rdchk(12, 'h40, "R6");
        set_uf = 1'b1; op(1, 0, 12, 0); set_uf = 1'b0;
        chk("R4", int'(bus_rdata), 'h00);
        rdchk(12, 'h10, "R4");

        // UIP window
        refresh = 1'b1; idle(1); refresh = 1'b0;
        rdchk(10, 'hA6, "R9");
        tick = 1'b1; idle(TICKS - 1); tick = 1'b0;
        rdchk(10, 'hA6, "R9");
        tick = 1'b1; idle(1); tick = 1'b0;
        rdchk(10, 'h26, "R9");
        refresh = 1'b1; idle(1); refresh = 1'b0;
        tick = 1'b1; idle(10); refresh = 1'b1; idle(1); refresh = 1'b0;
        idle(TICKS - 1); tick = 1'b0;
        rdchk(10, 'hA6, "R9");
        tick = 1'b1; idle(1); tick = 1'b0;
        rdchk(10, 'h26, "R9");

        // Indexed mode
        map_direct = 1'b0;
        op(0, 1, 0, 'hE1);
        op(0, 1, 1, 'h5A);
        rdchk(1, 'h5A, "R1");
        rdchk(0, 'h00, "R1");
        op(0, 1, 0, 'h00);
        op(0, 1, 1, 'hC3);
        rdchk(1, 'h43, "R2");
        map_direct = 1'b1;
        rdchk('h21, 'h5A, "R2");
        op(0, 1, 'h22, 'h33);
        map_direct = 1'b0;
        op(0, 1, 0, 'h22);
        rdchk(1, 'h33, "R2");
        op(0, 1, 0, 13);
        rdchk(1, 'h80, "R5");

        // Random phase, checked by the model every clock
        for (int n = 0; n < 3000; n++) begin
            int r;
            int a;
            r = $urandom_range(0, 9);
            a = $urandom_range(0, 7);
            map_direct = 1'($urandom_range(0, 1));
            tick       = 1'($urandom_range(0, 1));
            refresh    = ($urandom_range(0, 40) == 0);
            set_pf     = ($urandom_range(0, 15) == 0);
            set_af     = ($urandom_range(0, 15) == 0);
            set_uf     = ($urandom_range(0, 15) == 0);
            case (a)
                0: bus_addr = 6'd0;
                1: bus_addr = 6'd10;
                2: bus_addr = 6'd11;
                3: bus_addr = 6'd12;
                4: bus_addr = 6'd13;
                5: bus_addr = 6'd1;
                default: bus_addr = 6'($urandom_range(0, 63));
            endcase
            bus_wdata = 8'($urandom_range(0, 255));
            if (!map_direct && bus_addr[0] == 1'b0 && $urandom_range(0, 1) == 1)
                bus_wdata = 8'($urandom_range(10, 13));
            bus_rd = (r < 4);
            bus_wr = (r >= 4) && (r < 7);
            @(negedge clk);
        end
        bus_rd = 1'b0; bus_wr = 1'b0; tick = 1'b0; refresh = 1'b0;
        set_pf = 1'b0; set_af = 1'b0; set_uf = 1'b0;
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule